// File: doc/BRIEF.md
# Conveyor Pitch Tracking Diverter

This block follows items along an indexed conveyor and opens a diverter valve when a marked item reaches the valve's station. Each bit of a long tracking register stands for one pitch position. Index 0 is the conveyor entry, and each higher index lies one pitch further downstream. An operator request marks the next item to enter. The mark is held in a pending stage until the next pitch event, when it is shifted into the entry position.

The pitch sensor is a raw level input. It passes through a flop synchronizer, and only its rising edge advances the register. A station offset input selects which positions drive the valve, and the valve output is registered.

A build parameter selects one of two window variants. In the wide-window variant, the three positions centred on the offset are ORed together. In the feed variant, each request pushes three consecutive marked pitches, and only the single position one below the offset is tested. For an isolated request, both variants give the same valve timing.

The pending stage is a small state machine with three states:
- P_IDLE: nothing pending. A request moves it to P_ARMED.
- P_ARMED: a mark waits for the next pitch event. On that event in the wide-window variant, it returns to P_IDLE, or stays in P_ARMED if a request arrives in the same cycle. On that event in the feed variant, it moves to P_FEED with two further marked pitches to push.
- P_FEED: each pitch event pushes one more mark and counts down. After the last one it goes to P_ARMED if a request arrived while feeding, and otherwise to P_IDLE.

Top module: `pitch_divert`

## Requirements
- R1: Synchronous reset clears the tracking register, the pending stage and the valve output. After reset the valve reads 0, and pitch events without requests keep it at 0.
- R2: A request pulse sets the pending mark. The next pitch event writes that mark into position 0 (the entry position), so with an offset of 1 the valve is 1 after that single event.
- R3: Each pitch event moves every position up by one index, and the content of the top position (319 for the default 320-bit register) is discarded. With offset 318, a single mark drives the valve after events 318, 319 and 320 counted from its entry, and no longer after event 321.
- R4: Only a rising edge of the synchronized pitch level is a pitch event. Holding the sensor high for many cycles advances the register exactly once.
- R5: After a shift in the wide-window variant, the pending mark is cleared unless a request arrived in that same cycle, so later events insert 0.
- R6: A request that coincides with a pitch event is kept for the following event. The event itself inserts whatever was pending before it (0 if nothing was pending).
- R7: In the wide-window variant, the valve is 1 exactly when any of positions offset−1, offset and offset+1 holds a mark. Offsets up to 318 (including 130 and above) are usable.
- R8: An offset of 0 or one above 318 forces the valve to 0, whatever the register holds.
- R9: The valve is registered. It changes one clock after the cycle in which the register shifts, and keeps its previous value during that cycle.
- R10: In the feed variant, a request inserts marks on three consecutive pitch events, and the valve follows only position offset−1. A request arriving during feeding starts a new feed after the current one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Operator divert request pulse |
| pitch_in | input | 1 | Raw pitch sensor level |
| ofs | input | OFS_W (9) | Valve station offset in pitches |
| valve | output | 1 | Registered diverter valve drive |

## Verification
Both variants are driven side by side by the same stimulus and compared against bench models of the register and the pending stage.

Directed runs cover the following patterns, each separating a different behaviour:
- A lone request at a small offset separates entry placement from window width.
- A mark followed to the top of the register shows where discarding starts.
- Long sensor-high periods tell edge detection apart from level sampling.
- Requests placed in the exact cycle of a pitch event show whether a coinciding request is held or lost.

Random runs mix sparse and dense requests with offset changes, including out-of-range values. Dense requests separate the feed variant's queued re-arming from the wide-window OR.

// File: rtl/pitch_divert_pkg.sv
`timescale 1ns/1ps
package pitch_divert_pkg;
    typedef enum logic [1:0] {
        P_IDLE  = 2'd0,
        P_ARMED = 2'd1,
        P_FEED  = 2'd2
    } pend_state_e;

    localparam int FEED_EXTRA = 2;
endpackage

// File: rtl/pitch_sync.sv
`timescale 1ns/1ps
module pitch_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pitch_raw,
    output logic ev
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;
    logic              lvl;

    assign lvl = sync_q[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], pitch_raw};
            prev_q <= lvl;
        end
    end

    assign ev = lvl & ~prev_q;
endmodule

// File: rtl/pitch_pending.sv
`timescale 1ns/1ps
module pitch_pending
    import pitch_divert_pkg::*;
#(
    parameter bit TRIPLE = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  logic ev,
    output logic pend_bit
);
    pend_state_e state_q, state_d;
    logic [1:0]  feed_q, feed_d;
    logic        held_q, held_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= P_IDLE;
            feed_q  <= '0;
            held_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            feed_q  <= feed_d;
            held_q  <= held_d;
        end
    end

    always_comb begin
        state_d = state_q;
        feed_d  = feed_q;
        held_d  = held_q;
        unique case (state_q)
            P_IDLE: begin
                if (req) state_d = P_ARMED;
            end
            P_ARMED: begin
                if (ev) begin
                    if (TRIPLE) begin
                        state_d = P_FEED;
                        feed_d  = 2'(FEED_EXTRA);
                        held_d  = req;
                    end else if (!req) begin
                        state_d = P_IDLE;
                    end
                end
            end
            P_FEED: begin
                if (req) held_d = 1'b1;
                if (ev) begin
                    if (feed_q == 2'd1) begin
                        state_d = (held_q || req) ? P_ARMED : P_IDLE;
                        held_d  = 1'b0;
                        feed_d  = '0;
                    end else begin
                        feed_d = feed_q - 2'd1;
                    end
                end
            end
            default: state_d = P_IDLE;
        endcase
    end

    always_comb begin
        pend_bit = (state_q != P_IDLE);
    end
endmodule

// File: rtl/pitch_track.sv
`timescale 1ns/1ps
module pitch_track #(
    parameter int LEN = 320
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           ev,
    input  logic           bit_in,
    output logic [LEN-1:0] track_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            track_q <= '0;
        end else if (ev) begin
            track_q <= {track_q[LEN-2:0], bit_in};
        end
    end
endmodule

// File: rtl/pitch_window.sv
`timescale 1ns/1ps
module pitch_window #(
    parameter int LEN    = 320,
    parameter int OFS_W  = 9,
    parameter bit TRIPLE = 1'b0
) (
    input  logic [LEN-1:0]   track,
    input  logic [OFS_W-1:0] ofs,
    output logic             hit
);
    localparam logic [OFS_W-1:0] OFS_MAX = OFS_W'(LEN - 2);

    logic             in_range;
    logic [OFS_W-1:0] lo;
    logic [LEN-1:0]   shifted;

    assign in_range = (ofs != '0) && (ofs <= OFS_MAX);
    assign lo       = ofs - OFS_W'(1);
    assign shifted  = track >> lo;

    generate
        if (TRIPLE) begin : g_single_tap
            assign hit = in_range & shifted[0];
        end else begin : g_three_tap
            assign hit = in_range & (|shifted[2:0]);
        end
    endgenerate
endmodule

// File: rtl/pitch_divert.sv
`timescale 1ns/1ps
module pitch_divert #(
    parameter int TRACK_LEN   = 320,
    parameter int SYNC_STAGES = 2,
    parameter bit TRIPLE_FEED = 1'b0,
    parameter int OFS_W       = $clog2(TRACK_LEN)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic             pitch_in,
    input  logic [OFS_W-1:0] ofs,
    output logic             valve
);
    logic                 pitch_ev;
    logic                 pend_bit;
    logic [TRACK_LEN-1:0] track_q;
    logic                 hit;
    logic                 valve_q;

    pitch_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .pitch_raw(pitch_in),
        .ev       (pitch_ev)
    );

    pitch_pending #(.TRIPLE(TRIPLE_FEED)) u_pend (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .ev      (pitch_ev),
        .pend_bit(pend_bit)
    );

    pitch_track #(.LEN(TRACK_LEN)) u_track (
        .clk    (clk),
        .rst    (rst),
        .ev     (pitch_ev),
        .bit_in (pend_bit),
        .track_q(track_q)
    );

    pitch_window #(.LEN(TRACK_LEN), .OFS_W(OFS_W), .TRIPLE(TRIPLE_FEED)) u_win (
        .track(track_q),
        .ofs  (ofs),
        .hit  (hit)
    );

    always_ff @(posedge clk) begin
        if (rst) valve_q <= 1'b0;
        else     valve_q <= hit;
    end

    assign valve = valve_q;
endmodule

// File: rtl/pitch_divert_chk.sv
`timescale 1ns/1ps
module pitch_divert_chk #(
    parameter int TRACK_LEN   = 320,
    parameter bit TRIPLE_FEED = 1'b0,
    parameter int OFS_W       = 9
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 req,
    input logic [OFS_W-1:0]     ofs,
    input logic                 valve,
    input logic                 ev,
    input logic                 pend_bit,
    input logic [TRACK_LEN-1:0] track
);
    localparam logic [OFS_W-1:0] OFS_MAX = OFS_W'(TRACK_LEN - 2);

    AST_RESET_CLEARS: assert property (@(posedge clk) $past(rst) |-> !valve); // R1
    AST_ENTRY_BIT: assert property (@(posedge clk) disable iff (rst)
        $past(ev) |-> (track[0] == $past(pend_bit))); // R2
    AST_MOVE_UP: assert property (@(posedge clk) disable iff (rst)
        $past(ev) |-> (track[TRACK_LEN-1:1] == $past(track[TRACK_LEN-2:0]))); // R3
    AST_NO_SHIFT_IDLE: assert property (@(posedge clk) disable iff (rst)
        !$past(ev) |-> $stable(track)); // R4
    AST_PEND_CLEARED: assert property (@(posedge clk) disable iff (rst)
        (!TRIPLE_FEED && $past(ev) && !$past(req)) |-> !pend_bit); // R5
    AST_REQ_KEPT: assert property (@(posedge clk) disable iff (rst)
        $past(req) |-> pend_bit); // R6
    AST_OFS_BLOCK: assert property (@(posedge clk) disable iff (rst)
        ((ofs == '0) || (ofs > OFS_MAX)) |=> !valve); // R8
endmodule

bind pitch_divert pitch_divert_chk #(
    .TRACK_LEN  (TRACK_LEN),
    .TRIPLE_FEED(TRIPLE_FEED),
    .OFS_W      (OFS_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .req     (req),
    .ofs     (ofs),
    .valve   (valve),
    .ev      (pitch_ev),
    .pend_bit(pend_bit),
    .track   (track_q)
);

// File: tb/pitch_divert_test.sv
`timescale 1ns/1ps
module pitch_divert_test;
    localparam int LEN = 320;
    localparam int OW  = 9;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req = 1'b0;
    logic          pitch_in = 1'b0;
    logic [OW-1:0] ofs = '0;
    logic          valve_s;
    logic          valve_t;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [LEN-1:0] ms, mt;
    bit  pend_s, pend_t;
    int  feed_t;

    always #5 clk = ~clk;

    pitch_divert #(.TRACK_LEN(LEN), .TRIPLE_FEED(1'b0)) uut (
        .clk(clk), .rst(rst), .req(req), .pitch_in(pitch_in), .ofs(ofs), .valve(valve_s)
    );

    pitch_divert #(.TRACK_LEN(LEN), .TRIPLE_FEED(1'b1)) uut_tri (
        .clk(clk), .rst(rst), .req(req), .pitch_in(pitch_in), .ofs(ofs), .valve(valve_t)
    );

    function automatic bit win(input logic [LEN-1:0] m, input int o, input bit tri_mode);
        if (o < 1 || o > LEN - 2) return 1'b0;
        if (tri_mode) return m[o-1];
        return m[o-1] | m[o] | m[o+1];
    endfunction

    task automatic chk(input string tag, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: valve got %b expected %b at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic do_req();
        @(negedge clk) req = 1'b1;
        @(negedge clk) req = 1'b0;
        pend_s = 1'b1;
        pend_t = 1'b1;
    endtask

    task automatic do_pitch(input string tag, input int high_len, input bit req_edge);
        bit pre_s, pre_t, in_t;
        @(negedge clk) pitch_in = 1'b1;
        pre_s = win(ms, int'(ofs), 1'b0);
        pre_t = win(mt, int'(ofs), 1'b1);
        @(negedge clk);
        @(negedge clk) if (req_edge) req = 1'b1;
        @(negedge clk) req = 1'b0;
        chk("R9", valve_s, pre_s);
        chk("R9", valve_t, pre_t);
        ms = {ms[LEN-2:0], pend_s};
        pend_s = req_edge;
        if (feed_t > 0) begin
            in_t = 1'b1; feed_t--; pend_t = pend_t | req_edge;
        end else if (pend_t) begin
            in_t = 1'b1; feed_t = 2; pend_t = req_edge;
        end else begin
            in_t = 1'b0; pend_t = req_edge;
        end
        mt = {mt[LEN-2:0], in_t};
        @(negedge clk);
        chk(tag, valve_s, win(ms, int'(ofs), 1'b0));
        chk("R10", valve_t, win(mt, int'(ofs), 1'b1));
        if (high_len > 0) begin
            repeat (high_len) @(negedge clk);
            chk("R4", valve_s, win(ms, int'(ofs), 1'b0));
            chk("R4", valve_t, win(mt, int'(ofs), 1'b1));
        end
        pitch_in = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        ms = '0; mt = '0; pend_s = 0; pend_t = 0; feed_t = 0;
        ofs = OW'(5);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", valve_s, 1'b0);
        chk("R1", valve_t, 1'b0);
        for (int i = 0; i < 3; i++) do_pitch("R1", 0, 1'b0);

        // Entry position: offset 1 sees bit 0
        ofs = OW'(1);
        do_req();
        do_pitch("R2", 0, 1'b0);
        for (int i = 0; i < 8; i++) do_pitch("R5", 0, 1'b0);

        // Lone mark passing a mid offset
        ofs = OW'(5);
        do_req();
        for (int i = 0; i < 10; i++) do_pitch("R7", 0, 1'b0);

        // Request coinciding with an event
        do_pitch("R6", 0, 1'b1);
        for (int i = 0; i < 8; i++) do_pitch("R6", 0, 1'b0);
        do_req();
        do_pitch("R6", 0, 1'b1);
        for (int i = 0; i < 8; i++) do_pitch("R6", 0, 1'b0);

        // Long high level: single shift each
        do_req();
        for (int i = 0; i < 6; i++) do_pitch("R4", 20, 1'b0);

        // Out-of-range offsets with marks present
        do_req();
        do_pitch("R8", 0, 1'b0);
        ofs = OW'(0);
        do_pitch("R8", 0, 1'b0);
        ofs = OW'(319);
        do_pitch("R8", 0, 1'b0);
        ofs = OW'(511);
        do_pitch("R8", 0, 1'b0);

        // Far end: discard beyond top position, large offset
        ofs = OW'(318);
        do_req();
        for (int i = 0; i < 330; i++) do_pitch("R3", 0, 1'b0);

        ofs = OW'(130);
        do_req();
        for (int i = 0; i < 140; i++) do_pitch("R7", 0, 1'b0);

        // Random mix
        for (int i = 0; i < 300; i++) begin
            int r;
            if (($urandom % 8) == 0) begin
                r = $urandom % 10;
                if (r == 0)      ofs = OW'(0);
                else if (r == 1) ofs = OW'(319 + ($urandom % 193));
                else             ofs = OW'(1 + ($urandom % 40));
            end
            if (($urandom % 4) == 0) do_req();
            do_pitch("R7", (($urandom % 6) == 0) ? 5 : 0, (($urandom % 10) == 0));
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule